// File: doc/BRIEF.md
# Sector Write-Protect Unlock Sequencer

This block watches every completed access on a word-addressed memory bus and picks out a fixed ten-step command pattern. The pattern opens with six reads at specific addresses, which form the key. Three writes follow: a protection byte, its bitwise inverse, and a closing word whose data does not matter. A read of word zero ends the pattern. When the inverse check passes, the protection byte is copied into an 8-bit sector mask. Any access that does not fit the pattern sends the sequencer back to the start, and the mask keeps its old value.

The 18-bit word space is split into eight equal sectors of 32K words. Sector n is selected by address bits [17:15] = n. The block drives a combinational flag that says whether the address now on the bus falls in a protected sector. It also drives a suppress flag that marks write data belonging to the pattern, so the surrounding memory never stores those words. The mask stands in for nonvolatile storage: it is a plain register, cleared on reset. Bus timing is handled outside this block, which sees one completed access per `acc_valid` cycle.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset the mask reads 8'h00, and `addr_prot` is 0 for every address.
- R2: Six reads at 24555h, 3AAAAh, 02333h, 1CCCCh, 000FFh, 3EF00h, then a write of byte B to 3AAAAh and a write of ~B to 1CCCCh, set the mask to B. The new value shows on `wp_mask` from the cycle after the inverse write. A write to 0FF00h (any data) and a read of 00000h then close the pattern.
- R3: `addr_prot` equals mask bit n, where n = `acc_addr[17:15]`. A 1 bit protects its sector.
- R4: If the second data byte is not the exact bitwise inverse of the first, the pattern aborts and the mask keeps its value.
- R5: A read out of order, or a seventh read where the first write is expected, aborts the pattern and leaves the mask unchanged.
- R6: `seq_suppress` is never asserted for a read, including the key reads, so those reads return array data as normal.
- R7: `seq_suppress` is 1 for every write presented while the sequencer expects one of the three pattern writes, whether or not that write matches. It is 0 for writes at any other time.
- R8: The first key read is taken only if `acc_fresh` = 1 (the access opened a new chip selection), or if the access just before it was a read of 00000h.
- R9: The access that breaks a pattern is checked again as a possible first key read. A new key that begins on that access is then recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One completed bus access this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_fresh | input | 1 | Access began with a fresh chip selection |
| acc_addr | input | 18 | Word address of the access |
| acc_data | input | 8 | Low data byte of a write |
| wp_mask | output | 8 | Current sector protection mask |
| addr_prot | output | 1 | Current address lies in a protected sector |
| seq_suppress | output | 1 | Current write belongs to the pattern and must not reach the array |

## Verification
The full pattern is applied with several protection bytes. The stored mask must be exactly the written byte, which separates a real commit from a stuck or partial one. Near-miss patterns are also applied: a wrong inverse, a skipped key step, an extra seventh read, an entry with no fresh select and no preceding zero read, and a restart on the very access that broke the pattern. Each one tells a correct abort or restart apart from a sequencer that is too loose or too strict. Sector-edge addresses such as 17FFFh and 18000h confirm which address bits select the mask bit. Random traffic, seeded with key addresses and random complete or corrupted patterns, is checked against a reference model for the mask, the protection flag and the suppress flag.

// File: rtl/wp_seq_pkg.sv
// Package: shared constants for the unlock sequencer.
// Holds the step encoding and the expected address and direction of each step.
// Assumes word addresses are 18 bits wide.
package wp_seq_pkg;
    localparam int KEY_AW    = 18;
    localparam int STEP_W    = 4;
    typedef logic [STEP_W-1:0] step_t;

    localparam step_t STEP_IDLE = 4'd0;
    localparam step_t STEP_BYTE = 4'd6;
    localparam step_t STEP_CPL  = 4'd7;
    localparam step_t STEP_TAIL = 4'd8;
    localparam step_t STEP_EXIT = 4'd9;

    // Address the sequencer expects at a given step.
    function automatic logic [KEY_AW-1:0] step_addr(input step_t s);
        case (s)
            4'd0:    step_addr = 18'h24555;
            4'd1:    step_addr = 18'h3AAAA;
            4'd2:    step_addr = 18'h02333;
            4'd3:    step_addr = 18'h1CCCC;
            4'd4:    step_addr = 18'h000FF;
            4'd5:    step_addr = 18'h3EF00;
            4'd6:    step_addr = 18'h3AAAA;
            4'd7:    step_addr = 18'h1CCCC;
            4'd8:    step_addr = 18'h0FF00;
            default: step_addr = 18'h00000;
        endcase
    endfunction

    // Direction the sequencer expects at a given step (1 = write).
    function automatic logic step_is_wr(input step_t s);
        step_is_wr = (s >= STEP_BYTE) && (s <= STEP_TAIL);
    endfunction
endpackage

// File: rtl/wp_step_decode.sv
// Module: wp_step_decode
// Compares the presented access with the pattern step now expected, and with
// the first key step. Purely combinational; the caller gates with access valid.
module wp_step_decode
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  step_t             step,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit_here,
    output logic              hit_first
);
    logic [ADDR_W-1:0] want_addr;
    logic [ADDR_W-1:0] first_addr;

    // Expected addresses for the current and first steps.
    always_comb begin
        want_addr  = ADDR_W'(step_addr(step));
        first_addr = ADDR_W'(step_addr(STEP_IDLE));
    end

    // Address and direction match flags.
    always_comb begin
        hit_here  = (acc_addr == want_addr) && (acc_write == step_is_wr(step));
        hit_first = (acc_addr == first_addr) && !acc_write;
    end
endmodule

// File: rtl/wp_seq_fsm.sv
// Module: wp_seq_fsm
// Tracks progress through the ten-step pattern. Holds the pending protection
// byte, checks the inverse, and issues a commit strobe. On a mismatch the same
// access is retried as a first key step. Assumes one access per valid cycle.
module wp_seq_fsm
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_fresh,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MASK_W-1:0] acc_data,
    input  logic              hit_here,
    input  logic              hit_first,
    output step_t             step_q,
    output logic              commit,
    output logic [MASK_W-1:0] commit_val,
    output logic              suppress
);
    step_t             step_d;
    logic [MASK_W-1:0] pend_q;
    logic              zero_rd_q;
    logic              entry_ok;
    logic              cpl_ok;
    logic              adv;
    logic              restart;
    logic              in_wr_window;

    // Step qualification: entry rule, inverse check, advance and restart.
    always_comb begin
        entry_ok     = acc_fresh || zero_rd_q;
        cpl_ok       = (acc_data == ~pend_q);
        adv          = hit_here
                       && ((step_q != STEP_IDLE) || entry_ok)
                       && ((step_q != STEP_CPL) || cpl_ok);
        restart      = hit_first && entry_ok;
        in_wr_window = (step_q >= STEP_BYTE) && (step_q <= STEP_TAIL);
    end

    // Next-step selection.
    always_comb begin
        if (!acc_valid)
            step_d = step_q;
        else if (adv)
            step_d = (step_q == STEP_EXIT) ? STEP_IDLE : step_t'(step_q + 4'd1);
        else if (restart)
            step_d = 4'd1;
        else
            step_d = STEP_IDLE;
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= STEP_IDLE;
        else
            step_q <= step_d;
    end

    // Pending protection byte, captured on the first pattern write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (acc_valid && adv && (step_q == STEP_BYTE))
            pend_q <= acc_data;
    end

    // Remembers whether the previous access was a read of word zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_rd_q <= 1'b0;
        else if (acc_valid)
            zero_rd_q <= !acc_write && (acc_addr == '0);
    end

    // Commit strobe and write suppression toward the array.
    always_comb begin
        commit     = acc_valid && adv && (step_q == STEP_CPL);
        commit_val = pend_q;
        suppress   = acc_valid && acc_write && in_wr_window;
    end
endmodule

// File: rtl/wp_sector_reg.sv
// Module: wp_sector_reg
// Holds the sector protection mask (reset to all unprotected). Looks up the
// sector of the current address: the top SECT_W address bits pick one mask bit.
module wp_sector_reg #(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 3,
    localparam int MASK_W = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [MASK_W-1:0] commit_val,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [MASK_W-1:0] mask_q,
    output logic              addr_prot
);
    logic [SECT_W-1:0] sect_idx;
    logic [MASK_W-1:0] sect_hit;

    // Mask register, loaded only by a verified commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (commit)
            mask_q <= commit_val;
    end

    // Sector index from the top address bits.
    always_comb sect_idx = acc_addr[ADDR_W-1 -: SECT_W];

    // One match term per sector.
    for (genvar i = 0; i < MASK_W; i++) begin : g_sect
        assign sect_hit[i] = mask_q[i] && (sect_idx == SECT_W'(i));
    end

    // Protected if any selected sector bit is set.
    always_comb addr_prot = |sect_hit;
endmodule

// File: rtl/wp_unlock_seq.sv
// Module: wp_unlock_seq (top)
// Sector write-protect unlock sequencer. Recognises the ten-step pattern on
// completed bus accesses, updates the protection mask, and flags both
// protected addresses and pattern writes that must not reach the array.
module wp_unlock_seq
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 3,
    localparam int MASK_W = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_fresh,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MASK_W-1:0] acc_data,
    output logic [MASK_W-1:0] wp_mask,
    output logic              addr_prot,
    output logic              seq_suppress
);
    step_t             step_q;
    logic              hit_here;
    logic              hit_first;
    logic              commit;
    logic [MASK_W-1:0] commit_val;

    wp_step_decode #(.ADDR_W(ADDR_W)) u_dec (
        .step      (step_q),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .hit_here  (hit_here),
        .hit_first (hit_first)
    );

    wp_seq_fsm #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_fresh  (acc_fresh),
        .acc_addr   (acc_addr),
        .acc_data   (acc_data),
        .hit_here   (hit_here),
        .hit_first  (hit_first),
        .step_q     (step_q),
        .commit     (commit),
        .commit_val (commit_val),
        .suppress   (seq_suppress)
    );

    wp_sector_reg #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_sect (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_val (commit_val),
        .acc_addr   (acc_addr),
        .mask_q     (wp_mask),
        .addr_prot  (addr_prot)
    );
endmodule

// File: rtl/wp_unlock_seq_chk.sv
// Module: wp_unlock_seq_chk
// Port-level properties of the unlock sequencer, bound to the top module.
module wp_unlock_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [MASK_W-1:0] wp_mask,
    input logic              addr_prot,
    input logic              seq_suppress
);
    AST_RESET_CLEARS_MASK: assert property (@(posedge clk) !rst_n |=> (wp_mask == '0)); // R1
    AST_NO_CHANGE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || !acc_write) |=> $stable(wp_mask)); // R4
    AST_COMMIT_ONLY_AT_INVERSE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (acc_addr != ADDR_W'(18'h1CCCC))) |=> $stable(wp_mask)); // R2
    AST_READ_NEVER_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |-> !seq_suppress); // R6
    AST_IDLE_NEVER_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !seq_suppress); // R7
    AST_PROT_NEEDS_MASK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_prot |-> (wp_mask != '0)); // R3
    AST_FULL_MASK_PROTECTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_mask == '1) |-> addr_prot); // R3
endmodule

bind wp_unlock_seq wp_unlock_seq_chk #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .wp_mask      (wp_mask),
    .addr_prot    (addr_prot),
    .seq_suppress (seq_suppress)
);

// File: tb/tb_wp_unlock_seq.sv
// Bench for wp_unlock_seq: directed pattern cases plus seeded random traffic,
// checked against a reference model built from the requirements.
module tb_wp_unlock_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_fresh = 1'b0;
    logic [17:0] acc_addr = '0;
    logic [7:0]  acc_data = '0;
    logic [7:0]  wp_mask;
    logic        addr_prot;
    logic        seq_suppress;

    int checks = 0;
    int fails  = 0;

    logic [17:0] key_a [10];
    bit          key_w [10];
    int          m_step = 0;
    logic [7:0]  m_pend = '0;
    logic [7:0]  m_mask = '0;
    bit          m_zero = 1'b0;

    always #2.5 clk = ~clk;

    wp_unlock_seq dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_fresh(acc_fresh), .acc_addr(acc_addr), .acc_data(acc_data),
        .wp_mask(wp_mask), .addr_prot(addr_prot), .seq_suppress(seq_suppress)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: apply one access to the expected pattern state.
    task automatic model_apply(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit fr);
        bit ent = fr || m_zero;
        bit here = (a == key_a[m_step]) && (wr == key_w[m_step])
                   && (m_step != 0 || ent) && (m_step != 7 || d == ~m_pend);
        bit first = (a == key_a[0]) && !wr && ent;
        if (here) begin
            if (m_step == 6) m_pend = d;
            if (m_step == 7) m_mask = m_pend;
            m_step = (m_step == 9) ? 0 : m_step + 1;
        end else begin
            m_step = first ? 1 : 0;
        end
        m_zero = !wr && (a == 18'h0);
    endtask

    // One access: check mask, then the combinational flags, then advance.
    task automatic access(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit fr);
        @(negedge clk);
        check("R2 mask vs model", 32'(wp_mask), 32'(m_mask));
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_data = d; acc_fresh = fr;
        #1;
        check("R3 addr_prot", 32'(addr_prot), 32'(m_mask[a[17:15]]));
        if (wr) check("R7 write suppress", 32'(seq_suppress), 32'(m_step >= 6 && m_step <= 8));
        else    check("R6 read not suppressed", 32'(seq_suppress), 32'd0);
        model_apply(wr, a, d, fr);
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    task automatic check_mask(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, 32'(wp_mask), 32'(exp));
    endtask

    task automatic run_key(input bit fr);
        for (int i = 0; i < 6; i++) access(1'b0, key_a[i], 8'h00, (i == 0) ? fr : 1'b0);
    endtask

    task automatic tail_writes(input logic [7:0] b, input logic [7:0] c);
        access(1'b1, 18'h3AAAA, b, 1'b0);
        access(1'b1, 18'h1CCCC, c, 1'b0);
        access(1'b1, 18'h0FF00, 8'h5A, 1'b0);
        access(1'b0, 18'h00000, 8'h00, 1'b0);
    endtask

    initial begin
        key_a[0] = 18'h24555; key_a[1] = 18'h3AAAA; key_a[2] = 18'h02333;
        key_a[3] = 18'h1CCCC; key_a[4] = 18'h000FF; key_a[5] = 18'h3EF00;
        key_a[6] = 18'h3AAAA; key_a[7] = 18'h1CCCC; key_a[8] = 18'h0FF00;
        key_a[9] = 18'h00000;
        for (int i = 0; i < 10; i++) key_w[i] = (i >= 6 && i <= 8);
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state.
        check_mask("R1 reset mask", 8'h00);
        access(1'b0, 18'h3FFFF, 8'h00, 1'b1);

        // R2: full pattern with byte 18h protects sectors 3 and 4.
        run_key(1'b1);
        access(1'b1, 18'h3AAAA, 8'h18, 1'b0);
        access(1'b1, 18'h1CCCC, 8'hE7, 1'b0);
        check_mask("R2 commit 18h", 8'h18);
        access(1'b1, 18'h0FF00, 8'h33, 1'b0);
        access(1'b0, 18'h00000, 8'h00, 1'b0);

        // R3: sector edges.
        access(1'b0, 18'h17FFF, 8'h00, 1'b1);
        check("R3 17FFF unprotected", 32'(addr_prot), 32'd0);
        access(1'b0, 18'h18000, 8'h00, 1'b1);
        access(1'b1, 18'h27FFF, 8'hAA, 1'b1);
        access(1'b1, 18'h28000, 8'hAA, 1'b1);

        // R4: wrong inverse leaves mask.
        run_key(1'b1);
        tail_writes(8'hF0, 8'h0E);
        check_mask("R4 bad inverse keeps mask", 8'h18);

        // R5: skipped key step.
        access(1'b0, 18'h24555, 8'h00, 1'b1);
        access(1'b0, 18'h3AAAA, 8'h00, 1'b0);
        access(1'b0, 18'h1CCCC, 8'h00, 1'b0);
        access(1'b0, 18'h000FF, 8'h00, 1'b0);
        access(1'b0, 18'h3EF00, 8'h00, 1'b0);
        tail_writes(8'h01, 8'hFE);
        check_mask("R5 out of order keeps mask", 8'h18);

        // R5: seventh read after the key.
        run_key(1'b1);
        access(1'b0, 18'h3EF00, 8'h00, 1'b0);
        tail_writes(8'h01, 8'hFE);
        check_mask("R5 seventh read keeps mask", 8'h18);

        // R8: no fresh select and no zero read before: rejected.
        access(1'b0, 18'h00010, 8'h00, 1'b0);
        run_key(1'b0);
        tail_writes(8'h01, 8'hFE);
        check_mask("R8 entry refused", 8'h18);
        // R8: zero read before the key: accepted.
        access(1'b0, 18'h00000, 8'h00, 1'b0);
        run_key(1'b0);
        tail_writes(8'h01, 8'hFE);
        check_mask("R8 entry after zero read", 8'h01);

        // R9: the breaking access starts a new key.
        access(1'b0, 18'h24555, 8'h00, 1'b1);
        access(1'b0, 18'h3AAAA, 8'h00, 1'b0);
        access(1'b0, 18'h24555, 8'h00, 1'b1);
        for (int i = 1; i < 6; i++) access(1'b0, key_a[i], 8'h00, 1'b0);
        tail_writes(8'h55, 8'hAA);
        check_mask("R9 restart recognised", 8'h55);

        // R7: ordinary write outside the pattern is not suppressed.
        access(1'b1, 18'h3AAAA, 8'h12, 1'b1);
        check("R7 plain write passes", 32'(seq_suppress), 32'd0);

        // Random traffic.
        for (int n = 0; n < 400; n++) begin
            int sel = int'($urandom % 8);
            if (sel < 2) begin
                logic [7:0] b = 8'($urandom);
                logic [7:0] c = ($urandom % 4 == 0) ? 8'($urandom) : ~b;
                run_key(($urandom % 2) == 1);
                tail_writes(b, c);
            end else if (sel == 2) begin
                int len = int'($urandom % 6);
                for (int i = 0; i < len; i++) access(1'b0, key_a[i], 8'h00, i == 0);
                access(($urandom % 2) == 1, key_a[$urandom % 10], 8'($urandom), 1'b0);
            end else begin
                logic [17:0] a = ($urandom % 2 == 1) ? key_a[$urandom % 10] : 18'($urandom);
                access(($urandom % 2) == 1, a, 8'($urandom), ($urandom % 2) == 1);
            end
        end
        check_mask("R2 final mask vs model", m_mask);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule